// File: doc/BRIEF.md
# Dual JTAG Pin-Group Selector

This block sits between one internal test access port (TAP) and two external pin groups. The dedicated debug group has its own clock, mode, data-in and data-out pins. The application group borrows four general-purpose port pins. The application group becomes the active one only under three conditions: the test-select pin is high, the external test-reset pin is low, and a software control flag is set. In every other case the dedicated group drives the TAP. The group that is not selected is parked toward the TAP with a quiet clock and mode held high, so its pins cannot disturb the TAP.

The block also owns the direction of the shared TDO port bit. That bit is tristate during system reset. When the control flag is set while the test-select pin is high, the bit is pushed into a special output mode, and it stays there until software next programs the port. When the application group is not selected, the shared bits fall back to the values that software configured. The flag has two write sources: a register write port and a write from a special-function ROM. It reads back at a fixed register address.

All pin inputs pass through a synchronizer before use, and every output is registered. The block is built for a design where the TAP clock is oversampled by the system clock.

Top module: `jtag_dual_sel`

## Requirements
- R1: While `rst` is high, and in the cycle after it, the control flag reads 0, every `port_oe` bit and `dbg_tdo_oe` are 0, and the TAP sees `tap_tck`=0, `tap_tms`=1, `tap_tdi`=0 and `tap_ntrst`=0.
- R2: The application group is selected only when the synchronized test-select pin is 1, the synchronized `ntrst_pin` is 0 and the control flag is 1. Otherwise the dedicated debug pins drive the TAP. A pin change reaches the TAP outputs SYNC_STAGES+1 cycles later.
- R3: The selection changes only in a cycle where the registered `tap_tck` is 0. While `tap_tck` is 1, the old group stays connected.
- R4: A group that is not selected has no effect on the TAP. Its clock is replaced by 0, its mode by 1 and its data by 0.
- R5: The shared port bits are assigned as follows: bit 0 is TDI, bit 1 is TMS, bit 2 is TCK and bit 3 is TDO.
- R6: `dbg_tdo` follows `tap_tdo` one cycle later. `dbg_tdo_oe` equals `tap_tdo_en` when the debug group is selected, and 0 otherwise. When the application group is selected, port bits 0–2 have `port_oe`=0, and bit 3 drives `tap_tdo` with enable `tap_tdo_en`.
- R7: When (synchronized test-select AND flag) rises, port bit 3 enters special mode, with `port_oe[3]`=1 and `port_out[3]`=`tap_tdo`. A pulse on `sw_cfg_we` leaves special mode. If both happen in the same cycle, entry wins.
- R8: A write with `cr_we`=1 and `cr_addr`=CR_ADDR loads `cr_wdata[FLAG_BIT]` into the flag on the next edge. `rom_we` loads `rom_flag` instead. If both write in the same cycle, the ROM write wins.
- R9: `cr_rdata` shows the flag at bit FLAG_BIT, with all other bits 0, one cycle after `cr_addr`=CR_ADDR. It shows 0 for any other address.
- R10: When the application group is not selected and bit 3 is not in special mode, `port_out`/`port_oe` equal `sw_port_out`/`sw_port_oe`, one cycle later.
- R11: `tap_ntrst` follows the synchronized `ntrst_pin` while the debug group is selected. It is held at 1 while the application group is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| test_sel_pin | input | 1 | Test-select pin |
| ntrst_pin | input | 1 | External test-reset pin, active low |
| dbg_tck | input | 1 | Dedicated group clock |
| dbg_tms | input | 1 | Dedicated group mode |
| dbg_tdi | input | 1 | Dedicated group data in |
| dbg_tdo | output | 1 | Dedicated group data out |
| dbg_tdo_oe | output | 1 | Dedicated group data-out enable |
| port_in | input | 3 | Shared port bits 0..2 read from the pads |
| port_out | output | 4 | Shared port bits output value |
| port_oe | output | 4 | Shared port bits output enable |
| sw_port_out | input | 4 | Software-configured port output value |
| sw_port_oe | input | 4 | Software-configured port output enable |
| sw_cfg_we | input | 1 | Software programs port bit 3 configuration |
| cr_we | input | 1 | Control register write strobe |
| cr_addr | input | ADDR_W | Control register address |
| cr_wdata | input | DATA_W | Control register write data |
| cr_rdata | output | DATA_W | Control register read data |
| rom_we | input | 1 | Special-function ROM flag write strobe |
| rom_flag | input | 1 | Flag value from the ROM write |
| tap_tck | output | 1 | Clock toward the TAP |
| tap_tms | output | 1 | Mode toward the TAP |
| tap_tdi | output | 1 | Data toward the TAP |
| tap_ntrst | output | 1 | Test reset toward the TAP, active low |
| tap_tdo | input | 1 | Data out of the TAP |
| tap_tdo_en | input | 1 | TAP data-out valid |

## Verification
Each result has a fixed latency:
- A pin change reaches the TAP outputs three edges later with the default two-stage synchronizer.
- A selection change adds one more edge on top of that, and waits for a low TAP clock.
- Flag writes, read data, TDO routing and software port values each appear one edge after the inputs are applied.

A behavioural reference model in the bench uses a queue as deep as the synchronizer. At every rising edge it advances the same latencies from the requirements. The outputs are compared at the falling edge that follows, so each expected value is compared in exactly the cycle it is due. Directed phases add explicit checks for the reset state, the bit mapping, holding the selection under a high clock, special-mode entry and exit, and the write-priority case.

// File: rtl/jtag_sel_pkg.sv
package jtag_sel_pkg;

  // one JTAG input triple as seen by the TAP
  typedef struct packed {
    logic tck;
    logic tms;
    logic tdi;
  } jtag_in_t;

  // shared port bit roles
  localparam int PBIT_TDI = 0;
  localparam int PBIT_TMS = 1;
  localparam int PBIT_TCK = 2;
  localparam int PBIT_TDO = 3;
  localparam int PORT_BITS = 4;

  // idle value presented for an unselected group
  localparam jtag_in_t JTAG_PARK = '{tck: 1'b0, tms: 1'b1, tdi: 1'b0};

  localparam int GRP_DBG = 0;
  localparam int GRP_APP = 1;
  localparam int N_GRP   = 2;

endpackage

// File: rtl/jtag_sync.sv
module jtag_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= '0;
          else     stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= '0;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/jtag_pin_gate.sv
module jtag_pin_gate
  import jtag_sel_pkg::*;
(
  input  logic     en,
  input  jtag_in_t pins,
  output jtag_in_t to_tap
);

  always_comb begin
    if (en) to_tap = pins;
    else    to_tap = JTAG_PARK;
  end

endmodule

// File: rtl/jtag_sel_ctrl.sv
module jtag_sel_ctrl #(
  parameter int              ADDR_W   = 4,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CR_ADDR = 4'h2,
  parameter int              FLAG_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_s,
  input  logic              ntrst_s,
  input  logic              tck_now,
  input  logic              cr_we,
  input  logic [ADDR_W-1:0] cr_addr,
  input  logic [DATA_W-1:0] cr_wdata,
  input  logic              rom_we,
  input  logic              rom_flag,
  input  logic              sw_cfg_we,
  output logic              flag_q,
  output logic              sel_q,
  output logic              special_q,
  output logic [DATA_W-1:0] rdata_q
);

  logic addr_hit;
  logic want_app;
  logic arm_cond;
  logic arm_cond_q;
  logic arm_rise;
  logic unused_wdata;

  assign addr_hit     = (cr_addr == CR_ADDR);
  assign want_app     = test_s & ~ntrst_s & flag_q;
  assign arm_cond     = test_s & flag_q;
  assign arm_rise     = arm_cond & ~arm_cond_q;
  assign unused_wdata = ^cr_wdata;

  // control flag: ROM write has priority over the register port
  always_ff @(posedge clk) begin
    if (rst)                     flag_q <= 1'b0;
    else if (rom_we)             flag_q <= rom_flag;
    else if (cr_we && addr_hit)  flag_q <= cr_wdata[FLAG_BIT];
  end

  // selection only moves while the forwarded clock is low
  always_ff @(posedge clk) begin
    if (rst)           sel_q <= 1'b0;
    else if (!tck_now) sel_q <= want_app;
  end

  // special output mode on TDO bit: entry beats software clear
  always_ff @(posedge clk) begin
    if (rst) begin
      arm_cond_q <= 1'b0;
      special_q  <= 1'b0;
    end else begin
      arm_cond_q <= arm_cond;
      if (arm_rise)       special_q <= 1'b1;
      else if (sw_cfg_we) special_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      rdata_q <= '0;
      if (addr_hit) rdata_q[FLAG_BIT] <= flag_q;
    end
  end

  a_r1_flag_cleared: assert property (@(posedge clk) rst |=> !flag_q);

  a_r3_switch_tck_low: assert property (@(posedge clk) disable iff (rst)
    (sel_q != $past(sel_q)) |-> !$past(tck_now));

  a_r2_app_needs_all: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_q) |-> $past(flag_q && test_s && !ntrst_s));

  a_r8_rom_priority: assert property (@(posedge clk) disable iff (rst)
    rom_we |=> (flag_q == $past(rom_flag)));

  a_r7_special_holds: assert property (@(posedge clk) disable iff (rst)
    (special_q && !sw_cfg_we) |=> special_q);

endmodule

// File: rtl/jtag_dual_sel.sv
module jtag_dual_sel
  import jtag_sel_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CR_ADDR     = 4'h2,
  parameter int                FLAG_BIT    = 0,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_sel_pin,
  input  logic              ntrst_pin,
  input  logic              dbg_tck,
  input  logic              dbg_tms,
  input  logic              dbg_tdi,
  output logic              dbg_tdo,
  output logic              dbg_tdo_oe,
  input  logic [2:0]        port_in,
  output logic [3:0]        port_out,
  output logic [3:0]        port_oe,
  input  logic [3:0]        sw_port_out,
  input  logic [3:0]        sw_port_oe,
  input  logic              sw_cfg_we,
  input  logic              cr_we,
  input  logic [ADDR_W-1:0] cr_addr,
  input  logic [DATA_W-1:0] cr_wdata,
  output logic [DATA_W-1:0] cr_rdata,
  input  logic              rom_we,
  input  logic              rom_flag,
  output logic              tap_tck,
  output logic              tap_tms,
  output logic              tap_tdi,
  output logic              tap_ntrst,
  input  logic              tap_tdo,
  input  logic              tap_tdo_en
);

  localparam int SYNC_W = 8;

  logic [SYNC_W-1:0] raw_pins;
  logic [SYNC_W-1:0] syn_pins;
  logic              test_s;
  logic              ntrst_s;
  logic              flag_q;
  logic              sel_q;
  logic              special_q;
  jtag_in_t          grp_pins [N_GRP];
  jtag_in_t          grp_tap  [N_GRP];
  logic [N_GRP-1:0]  grp_en;

  assign raw_pins = {test_sel_pin, ntrst_pin, dbg_tck, dbg_tms, dbg_tdi,
                     port_in[PBIT_TCK], port_in[PBIT_TMS], port_in[PBIT_TDI]};

  jtag_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_pins),
    .q   (syn_pins)
  );

  assign test_s  = syn_pins[7];
  assign ntrst_s = syn_pins[6];
  assign grp_pins[GRP_DBG] = '{tck: syn_pins[5], tms: syn_pins[4], tdi: syn_pins[3]};
  assign grp_pins[GRP_APP] = '{tck: syn_pins[2], tms: syn_pins[1], tdi: syn_pins[0]};
  assign grp_en[GRP_DBG]   = ~sel_q;
  assign grp_en[GRP_APP]   = sel_q;

  jtag_sel_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CR_ADDR(CR_ADDR), .FLAG_BIT(FLAG_BIT)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .test_s    (test_s),
    .ntrst_s   (ntrst_s),
    .tck_now   (tap_tck),
    .cr_we     (cr_we),
    .cr_addr   (cr_addr),
    .cr_wdata  (cr_wdata),
    .rom_we    (rom_we),
    .rom_flag  (rom_flag),
    .sw_cfg_we (sw_cfg_we),
    .flag_q    (flag_q),
    .sel_q     (sel_q),
    .special_q (special_q),
    .rdata_q   (cr_rdata)
  );

  genvar g;
  generate
    for (g = 0; g < N_GRP; g++) begin : g_gate
      jtag_pin_gate u_gate (
        .en     (grp_en[g]),
        .pins   (grp_pins[g]),
        .to_tap (grp_tap[g])
      );
    end
  endgenerate

  // TAP side: parked group contributes tck=0, tms=1, tdi=0
  always_ff @(posedge clk) begin
    if (rst) begin
      tap_tck   <= 1'b0;
      tap_tms   <= 1'b1;
      tap_tdi   <= 1'b0;
      tap_ntrst <= 1'b0;
    end else begin
      tap_tck   <= grp_tap[GRP_DBG].tck | grp_tap[GRP_APP].tck;
      tap_tms   <= grp_tap[GRP_DBG].tms & grp_tap[GRP_APP].tms;
      tap_tdi   <= grp_tap[GRP_DBG].tdi | grp_tap[GRP_APP].tdi;
      tap_ntrst <= sel_q ? 1'b1 : ntrst_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_tdo    <= 1'b0;
      dbg_tdo_oe <= 1'b0;
    end else begin
      dbg_tdo    <= tap_tdo;
      dbg_tdo_oe <= ~sel_q & tap_tdo_en;
    end
  end

  // shared input bits: inputs to the TAP when selected, software otherwise
  genvar b;
  generate
    for (b = 0; b < PORT_BITS; b++) begin : g_port
      if (b == PBIT_TDO) begin : g_tdo
        always_ff @(posedge clk) begin
          if (rst) begin
            port_oe[b]  <= 1'b0;
            port_out[b] <= 1'b0;
          end else if (special_q) begin
            port_oe[b]  <= 1'b1;
            port_out[b] <= tap_tdo;
          end else if (sel_q) begin
            port_oe[b]  <= tap_tdo_en;
            port_out[b] <= tap_tdo;
          end else begin
            port_oe[b]  <= sw_port_oe[b];
            port_out[b] <= sw_port_out[b];
          end
        end
      end else begin : g_in
        always_ff @(posedge clk) begin
          if (rst) begin
            port_oe[b]  <= 1'b0;
            port_out[b] <= 1'b0;
          end else if (sel_q) begin
            port_oe[b]  <= 1'b0;
            port_out[b] <= 1'b0;
          end else begin
            port_oe[b]  <= sw_port_oe[b];
            port_out[b] <= sw_port_out[b];
          end
        end
      end
    end
  endgenerate

  a_r1_tdo_tristate: assert property (@(posedge clk)
    rst |=> (port_oe == 4'b0000 && !dbg_tdo_oe));

  a_r6_one_tdo_source: assert property (@(posedge clk) disable iff (rst)
    dbg_tdo_oe |-> (port_oe[2:0] == $past(sw_port_oe[2:0])));

  a_r11_ntrst_released: assert property (@(posedge clk) disable iff (rst)
    $past(sel_q) |-> tap_ntrst);

endmodule

// File: tb/jtag_dual_sel_test.sv
module jtag_dual_sel_test;

  localparam int SYNC = 2;
  localparam logic [3:0] CRA = 4'h2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic test_sel_pin = 0, ntrst_pin = 1;
  logic dbg_tck = 0, dbg_tms = 1, dbg_tdi = 0;
  logic [2:0] port_in = 3'b010;
  logic [3:0] sw_port_out = 0, sw_port_oe = 0;
  logic sw_cfg_we = 0, cr_we = 0, rom_we = 0, rom_flag = 0;
  logic [3:0] cr_addr = CRA;
  logic [7:0] cr_wdata = 0;
  logic tap_tdo = 0, tap_tdo_en = 0;
  logic dbg_tdo, dbg_tdo_oe, tap_tck, tap_tms, tap_tdi, tap_ntrst;
  logic [3:0] port_out, port_oe;
  logic [7:0] cr_rdata;

  int checks = 0;
  int fails = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  jtag_dual_sel uut (
    .clk(clk), .rst(rst), .test_sel_pin(test_sel_pin), .ntrst_pin(ntrst_pin),
    .dbg_tck(dbg_tck), .dbg_tms(dbg_tms), .dbg_tdi(dbg_tdi),
    .dbg_tdo(dbg_tdo), .dbg_tdo_oe(dbg_tdo_oe),
    .port_in(port_in), .port_out(port_out), .port_oe(port_oe),
    .sw_port_out(sw_port_out), .sw_port_oe(sw_port_oe), .sw_cfg_we(sw_cfg_we),
    .cr_we(cr_we), .cr_addr(cr_addr), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata),
    .rom_we(rom_we), .rom_flag(rom_flag),
    .tap_tck(tap_tck), .tap_tms(tap_tms), .tap_tdi(tap_tdi), .tap_ntrst(tap_ntrst),
    .tap_tdo(tap_tdo), .tap_tdo_en(tap_tdo_en)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] m_sync[$];
  logic m_flag, m_sel, m_spec, m_arm;
  logic m_tck, m_tms, m_tdi, m_ntrst, m_dtdo, m_doe;
  logic [3:0] m_pout, m_poe;
  logic [7:0] m_rd;

  always @(posedge clk) begin : model
    logic [7:0] s;
    logic want, arm, sel_o, spec_o, flag_o;
    started = 1;
    if (rst) begin
      m_sync = {};
      for (int i = 0; i < SYNC; i++) m_sync.push_back(8'h00);
      m_flag = 0; m_sel = 0; m_spec = 0; m_arm = 0;
      m_tck = 0; m_tms = 1; m_tdi = 0; m_ntrst = 0;
      m_dtdo = 0; m_doe = 0; m_pout = 0; m_poe = 0; m_rd = 0;
    end else begin
      s = m_sync.pop_front();
      m_sync.push_back({test_sel_pin, ntrst_pin, dbg_tck, dbg_tms, dbg_tdi, port_in[2], port_in[1], port_in[0]});
      sel_o = m_sel; spec_o = m_spec; flag_o = m_flag;
      want = s[7] & ~s[6] & flag_o;
      arm = s[7] & flag_o;
      if (!m_tck) m_sel = want;
      if (rom_we) m_flag = rom_flag;
      else if (cr_we && cr_addr == CRA) m_flag = cr_wdata[0];
      if (arm && !m_arm) m_spec = 1;
      else if (sw_cfg_we) m_spec = 0;
      m_arm = arm;
      m_tck = sel_o ? s[2] : s[5];
      m_tms = sel_o ? s[1] : s[4];
      m_tdi = sel_o ? s[0] : s[3];
      m_ntrst = sel_o ? 1'b1 : s[6];
      m_dtdo = tap_tdo;
      m_doe = ~sel_o & tap_tdo_en;
      m_pout[2:0] = sel_o ? 3'b000 : sw_port_out[2:0];
      m_poe[2:0]  = sel_o ? 3'b000 : sw_port_oe[2:0];
      if (spec_o) begin m_poe[3] = 1; m_pout[3] = tap_tdo; end
      else if (sel_o) begin m_poe[3] = tap_tdo_en; m_pout[3] = tap_tdo; end
      else begin m_poe[3] = sw_port_oe[3]; m_pout[3] = sw_port_out[3]; end
      m_rd = (cr_addr == CRA) ? {7'd0, flag_o} : 8'd0;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check({tap_tck, tap_tms, tap_tdi}, {m_tck, m_tms, m_tdi}, "R2/R4 tap inputs");
      check(tap_ntrst, m_ntrst, "R11 tap_ntrst");
      check({dbg_tdo, dbg_tdo_oe}, {m_dtdo, m_doe}, "R6 dbg tdo");
      check({port_out, port_oe}, {m_pout, m_poe}, "R10 port pins");
      check(cr_rdata, m_rd, "R9 readback");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_flag(input logic v);
    cr_we = 1; cr_addr = CRA; cr_wdata = {7'd0, v};
    cyc(1);
    cr_we = 0; cr_wdata = 0;
  endtask

  initial begin : main
    fork
      begin
        cyc(4);
        // R1 reset values held during reset
        check(port_oe, 4'b0, "R1 port_oe in reset");
        check({tap_tck, tap_tms, tap_tdi, tap_ntrst}, 4'b0100, "R1 tap in reset");
        check(dbg_tdo_oe, 1'b0, "R1 dbg_tdo_oe in reset");
        check(cr_rdata, 8'h00, "R1 flag clear");
        rst = 0;
        // debug group active, app pins toggled (R4)
        sw_port_out = 4'b1010; sw_port_oe = 4'b1111; tap_tdo_en = 1;
        for (int i = 0; i < 20; i++) begin
          dbg_tck = i[0]; dbg_tdi = i[1]; port_in = i[2:0]; tap_tdo = i[2];
          cyc(1);
        end
        dbg_tck = 0; port_in = 3'b010;
        // flag set with test high but ntrst high: R2 not selected, R7 special entered
        test_sel_pin = 1;
        cyc(3);
        wr_flag(1);
        cyc(4);
        check(port_oe[3], 1'b1, "R7 special mode entered");
        check(tap_ntrst, 1'b1, "R2 debug still selected, ntrst passes");
        sw_cfg_we = 1; cyc(1); sw_cfg_we = 0;
        sw_port_oe = 4'b0111; cyc(2);
        check(port_oe[3], 1'b0, "R7 special left after sw program");
        // select application group
        ntrst_pin = 0; cyc(6);
        check(tap_ntrst, 1'b1, "R11 ntrst held high in app mode");
        port_in = 3'b101; cyc(SYNC + 1);
        // R5 bit0=TDI bit1=TMS bit2=TCK
        check({tap_tck, tap_tms, tap_tdi}, 3'b101, "R5 port bit mapping");
        check(port_oe[2:0], 3'b000, "R6 port inputs in app mode");
        // R3: drop test select while app tck high
        test_sel_pin = 0; cyc(8);
        check(tap_ntrst, 1'b1, "R3 selection held while tck high");
        port_in = 3'b001; cyc(SYNC + 3);
        check(tap_ntrst, 1'b0, "R3 switched back after tck low");
        // R8 both writers in the same cycle, ROM wins
        cr_we = 1; cr_wdata = 8'h01; rom_we = 1; rom_flag = 0; cyc(1);
        cr_we = 0; rom_we = 0; cyc(1);
        check(cr_rdata, 8'h00, "R8 ROM write priority");
        rom_we = 1; rom_flag = 1; cyc(1); rom_we = 0; cyc(1);
        check(cr_rdata, 8'h01, "R8 ROM write sets flag");
        cr_addr = 4'h5; cyc(1);
        check(cr_rdata, 8'h00, "R9 other address reads zero");
        // random phase
        for (int i = 0; i < 4000; i++) begin
          dbg_tck = $urandom_range(0, 1); dbg_tms = $urandom_range(0, 1);
          dbg_tdi = $urandom_range(0, 1); port_in = 3'($urandom_range(0, 7));
          tap_tdo = $urandom_range(0, 1); tap_tdo_en = $urandom_range(0, 1);
          sw_port_out = 4'($urandom_range(0, 15)); sw_port_oe = 4'($urandom_range(0, 15));
          sw_cfg_we = ($urandom_range(0, 15) == 0);
          cr_addr = ($urandom_range(0, 3) == 0) ? 4'h7 : CRA;
          cr_we = ($urandom_range(0, 31) == 0); cr_wdata = 8'($urandom_range(0, 255));
          rom_we = ($urandom_range(0, 63) == 0); rom_flag = $urandom_range(0, 1);
          if ($urandom_range(0, 31) == 0) test_sel_pin = ~test_sel_pin;
          if ($urandom_range(0, 31) == 0) ntrst_pin = ~ntrst_pin;
          if (i == 2000) rst = 1;
          if (i == 2003) rst = 0;
          cyc(1);
        end
      end
      begin
        cyc(150000);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule